// File: doc/BRIEF.md
# Lamp Ballast Operating-Phase Sequencer

This block is the control state machine of a half-bridge lamp ballast. Once the supply is reported good it runs the lamp through three phases: a timed electrode preheat, an ignition sweep, and steady run. Alongside the phases it handles protection. Current-sense levels, an end-of-life window comparator and a low error-amplifier output can start a shortened, actively discharged timing cycle. When that cycle ends, the block either dismisses the event or locks itself into a low-power shutdown.

All analog behaviour is outside the block: the timing capacitor, the ignition capacitor, the oscillator and the comparators. The block sees only single-bit comparator flags. It returns single-bit enables for the timing-capacitor charge source, the active discharge sink and the clamp to ground. It also returns the ignition-capacitor clamp, the frequency-raising current sink, the half-bridge driver enable and a latched low-power indication. A single timing capacitor serves both the long preheat interval and the short fault-confirmation cycles.

Top module: `ballast_seq`

## Requirements
- R1: While `supply_ok` is 0 (and after reset), `drv_en` is 0, `tch_clamp` is 1, `eoi_clamp` is 1, `tch_charge` and `tch_sink` are 0, and `fault_latched` is 0. This holds even if the block was latched before.
- R2: After `supply_ok` rises with `shdn_req` at 0, preheat begins on the next edge. `tch_charge` is 1 until a clock edge samples `tch_hi`. After that all three timing controls are 0 (the capacitor floats) until an edge samples `tch_lo`. Ignition then begins with `tch_clamp` at 1.
- R3: `eoi_clamp` is 1 throughout preheat and is 0 during ignition and run. `drv_en` is 1 in preheat, ignition and run.
- R4: In ignition, `cs_mid` (the 1.6 V level) asserts `freq_up_sink` in the same cycle and starts a reduced timing cycle on the next edge. The reduced cycle drives `tch_charge` until `tch_hi` is sampled, then `tch_sink` until `tch_lo` is sampled, and then returns to `tch_clamp`.
- R5: At the end of an ignition reduced cycle the block latches if `cs_lim` (the 1.05 V level) is 1. Otherwise it stays in ignition.
- R6: In ignition, `eoi_run` moves the block to run on the next edge. On that same edge any active timing cycle is aborted and `tch_clamp` is asserted.
- R7: In run, `cs_lim` asserts `freq_up_sink` in the same cycle and starts a timing cycle. At the end of that cycle the block latches if `cs_test` (the 0.82 V level) is 1, and otherwise stays in run. `cs_lim` alone has no effect on `freq_up_sink` in ignition.
- R8: In run, `eol_win` or `comp_low` starts a timing cycle. At the end of the cycle the block latches only if a condition that started or joined the cycle is still 1.
- R9: In ignition, `cs_sat` (the 2.75 V level) latches the block on the next edge, without a timing cycle.
- R10: In run, `cs_mid` held for `RUN_SAT_CYC` consecutive edges (default 3) latches the block. A shorter pulse does not.
- R11: If the block is not latched, `shdn_req` clears `drv_en` on the next edge. The sequence restarts at preheat charge on the edge after `shdn_req` drops. When the block is latched, `shdn_req` has no effect.
- R12: When latched, `fault_latched` is 1, `drv_en` is 0, `tch_clamp` and `eoi_clamp` are 1, and this state persists until `supply_ok` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above turn-on level |
| shdn_req | input | 1 | External shutdown request |
| tch_hi | input | 1 | Timing capacitor reached upper threshold |
| tch_lo | input | 1 | Timing capacitor fell to lower threshold |
| eoi_run | input | 1 | Ignition capacitor reached run threshold |
| cs_test | input | 1 | Current sense above 0.82 V recheck level |
| cs_lim | input | 1 | Current sense above 1.05 V level |
| cs_mid | input | 1 | Current sense above 1.6 V level |
| cs_sat | input | 1 | Current sense above 2.75 V level |
| eol_win | input | 1 | End-of-life window violated |
| comp_low | input | 1 | Error amplifier saturated low |
| tch_charge | output | 1 | Timing capacitor charge source on |
| tch_sink | output | 1 | Timing capacitor active discharge on |
| tch_clamp | output | 1 | Timing capacitor clamped to ground |
| eoi_clamp | output | 1 | Ignition capacitor clamped to ground |
| freq_up_sink | output | 1 | Frequency-raising sink on ignition capacitor |
| drv_en | output | 1 | Half-bridge driver enable |
| fault_latched | output | 1 | Latched low-power shutdown |

## Verification
The checks assume the comparator flags are already synchronous and glitch-free. They also assume `tch_hi` and `tch_lo` are never 1 together. The bench drives every flag at the falling clock edge, raises each threshold flag only while the block is in the phase that examines it, and never raises both timing flags at once. The current-sense levels are nested in the sequences the bench produces, so a higher level never appears without the lower ones. The exception is `cs_test`, which the bench raises on its own to model current that has settled between the two lower levels.

// File: rtl/ballast_seq_pkg.sv
package ballast_seq_pkg;

   typedef enum logic [2:0] {
      PH_OFF     = 3'd0,
      PH_PRE_CHG = 3'd1,
      PH_PRE_FLT = 3'd2,
      PH_IGN     = 3'd3,
      PH_RUN     = 3'd4,
      PH_LATCH   = 3'd5
   } phase_e;

   typedef enum logic [1:0] {
      FC_IDLE = 2'd0,
      FC_CHG  = 2'd1,
      FC_SINK = 2'd2
   } fcyc_e;

   typedef struct packed {
      logic oc;
      logic eol;
      logic cmp;
   } cause_t;

endpackage

// File: rtl/ballast_fault_timer.sv
module ballast_fault_timer
   import ballast_seq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  abort_i,
   input  logic  start_i,
   input  logic  tch_hi_i,
   input  logic  tch_lo_i,
   output fcyc_e phase_o,
   output logic  done_o
);

   fcyc_e phase_q, phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         FC_IDLE: if (start_i)  phase_d = FC_CHG;
         FC_CHG:  if (tch_hi_i) phase_d = FC_SINK;
         FC_SINK: if (tch_lo_i) phase_d = FC_IDLE;
         default:               phase_d = FC_IDLE;
      endcase
      if (abort_i) phase_d = FC_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= FC_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase_o = phase_q;
   assign done_o  = (phase_q == FC_SINK) && tch_lo_i;

   // R4
   idle_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == FC_IDLE) |=> (phase_q != FC_SINK));

   // R4
   sink_after_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == FC_SINK) |-> ($past(phase_q) != FC_IDLE));

endmodule

// File: rtl/ballast_phase_ctrl.sv
module ballast_phase_ctrl
   import ballast_seq_pkg::*;
#(
   parameter int RUN_SAT_CYC = 3
)(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   supply_ok_i,
   input  logic   shdn_i,
   input  logic   tch_hi_i,
   input  logic   tch_lo_i,
   input  logic   eoi_run_i,
   input  logic   cs_test_i,
   input  logic   cs_lim_i,
   input  logic   cs_mid_i,
   input  logic   cs_sat_i,
   input  logic   eol_win_i,
   input  logic   comp_low_i,
   input  fcyc_e  fc_phase_i,
   input  logic   fc_done_i,
   output phase_e phase_o,
   output logic   fc_start_o,
   output logic   fc_abort_o
);

   localparam int CNT_W = (RUN_SAT_CYC > 1) ? $clog2(RUN_SAT_CYC) : 1;

   generate
      if (RUN_SAT_CYC < 1) begin : g_bad_sat
         $error("RUN_SAT_CYC must be at least 1");
      end
   endgenerate

   phase_e phase_q, phase_d;
   cause_t cause_q, cause_d, cause_now;
   logic   in_ign, in_run, active;
   logic   sat_run, verdict;

   assign in_ign = (phase_q == PH_IGN);
   assign in_run = (phase_q == PH_RUN);
   assign active = in_ign || in_run;

   // run-mode capacitive-mode detection: direct or persistence-filtered
   generate
      if (RUN_SAT_CYC == 1) begin : g_sat_direct
         assign sat_run = in_run && cs_mid_i;
      end else begin : g_sat_filt
         logic [CNT_W-1:0] sat_cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sat_cnt_q <= '0;
            else if (!(in_run && cs_mid_i))
               sat_cnt_q <= '0;
            else if (sat_cnt_q != CNT_W'(RUN_SAT_CYC - 1))
               sat_cnt_q <= sat_cnt_q + 1'b1;
         end
         assign sat_run = in_run && cs_mid_i &&
                          (sat_cnt_q == CNT_W'(RUN_SAT_CYC - 1));
      end
   endgenerate

   // conditions that open a timing cycle in run
   assign cause_now.oc  = in_run && cs_lim_i;
   assign cause_now.eol = in_run && eol_win_i;
   assign cause_now.cmp = in_run && comp_low_i;

   assign fc_start_o = (in_ign && cs_mid_i) ||
                       cause_now.oc || cause_now.eol || cause_now.cmp;

   always_comb begin
      if (in_ign)
         verdict = cs_lim_i;
      else
         verdict = ((cause_q.oc | cs_lim_i) & cs_test_i) |
                   (cause_q.eol & eol_win_i) |
                   (cause_q.cmp & comp_low_i);
   end

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_OFF:     if (!shdn_i) phase_d = PH_PRE_CHG;
         PH_PRE_CHG: if (shdn_i) phase_d = PH_OFF;
                     else if (tch_hi_i) phase_d = PH_PRE_FLT;
         PH_PRE_FLT: if (shdn_i) phase_d = PH_OFF;
                     else if (tch_lo_i) phase_d = PH_IGN;
         PH_IGN:     if (shdn_i) phase_d = PH_OFF;
                     else if (cs_sat_i) phase_d = PH_LATCH;
                     else if (fc_done_i && verdict) phase_d = PH_LATCH;
                     else if (eoi_run_i) phase_d = PH_RUN;
         PH_RUN:     if (shdn_i) phase_d = PH_OFF;
                     else if (sat_run) phase_d = PH_LATCH;
                     else if (fc_done_i && verdict) phase_d = PH_LATCH;
         PH_LATCH:   phase_d = PH_LATCH;
         default:    phase_d = PH_OFF;
      endcase
      if (!supply_ok_i) phase_d = PH_OFF;
   end

   assign fc_abort_o = !active || (phase_d != phase_q);

   always_comb begin
      if (fc_abort_o)
         cause_d = '0;
      else if (fc_phase_i == FC_IDLE)
         cause_d = cause_now;
      else
         cause_d = cause_q | cause_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
         cause_q <= '0;
      end else begin
         phase_q <= phase_d;
         cause_q <= cause_d;
      end
   end

   assign phase_o = phase_q;

   // R12
   latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_LATCH && supply_ok_i) |=> (phase_q == PH_LATCH));

   // R2
   preheat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IGN && $past(phase_q) != PH_IGN) |-> ($past(phase_q) == PH_PRE_FLT));

   // R1
   supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok_i |=> (phase_q == PH_OFF));

endmodule

// File: rtl/ballast_pin_drive.sv
module ballast_pin_drive
   import ballast_seq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_e phase_i,
   input  fcyc_e  fc_phase_i,
   input  logic   cs_mid_i,
   input  logic   cs_lim_i,
   output logic   tch_charge_o,
   output logic   tch_sink_o,
   output logic   tch_clamp_o,
   output logic   eoi_clamp_o,
   output logic   freq_up_o,
   output logic   drv_en_o,
   output logic   latched_o
);

   logic active, preheat;

   assign active  = (phase_i == PH_IGN) || (phase_i == PH_RUN);
   assign preheat = (phase_i == PH_PRE_CHG) || (phase_i == PH_PRE_FLT);

   assign tch_charge_o = (phase_i == PH_PRE_CHG) || (active && fc_phase_i == FC_CHG);
   assign tch_sink_o   = active && (fc_phase_i == FC_SINK);
   assign tch_clamp_o  = (phase_i == PH_OFF) || (phase_i == PH_LATCH) ||
                         (active && fc_phase_i == FC_IDLE);
   assign eoi_clamp_o  = !active;
   assign freq_up_o    = ((phase_i == PH_IGN) && cs_mid_i) ||
                         ((phase_i == PH_RUN) && cs_lim_i);
   assign drv_en_o     = preheat || active;
   assign latched_o    = (phase_i == PH_LATCH);

   // R2
   tch_ctrl_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tch_charge_o, tch_sink_o, tch_clamp_o}));

   // R12
   latched_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latched_o |-> (!drv_en_o && tch_clamp_o && eoi_clamp_o));

endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
   import ballast_seq_pkg::*;
#(
   parameter int RUN_SAT_CYC = 3
)(
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic shdn_req,
   input  logic tch_hi,
   input  logic tch_lo,
   input  logic eoi_run,
   input  logic cs_test,
   input  logic cs_lim,
   input  logic cs_mid,
   input  logic cs_sat,
   input  logic eol_win,
   input  logic comp_low,
   output logic tch_charge,
   output logic tch_sink,
   output logic tch_clamp,
   output logic eoi_clamp,
   output logic freq_up_sink,
   output logic drv_en,
   output logic fault_latched
);

   phase_e phase;
   fcyc_e  fc_phase;
   logic   fc_start, fc_abort, fc_done;

   ballast_phase_ctrl #(.RUN_SAT_CYC(RUN_SAT_CYC)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .supply_ok_i (supply_ok),
      .shdn_i      (shdn_req),
      .tch_hi_i    (tch_hi),
      .tch_lo_i    (tch_lo),
      .eoi_run_i   (eoi_run),
      .cs_test_i   (cs_test),
      .cs_lim_i    (cs_lim),
      .cs_mid_i    (cs_mid),
      .cs_sat_i    (cs_sat),
      .eol_win_i   (eol_win),
      .comp_low_i  (comp_low),
      .fc_phase_i  (fc_phase),
      .fc_done_i   (fc_done),
      .phase_o     (phase),
      .fc_start_o  (fc_start),
      .fc_abort_o  (fc_abort)
   );

   ballast_fault_timer u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .abort_i  (fc_abort),
      .start_i  (fc_start),
      .tch_hi_i (tch_hi),
      .tch_lo_i (tch_lo),
      .phase_o  (fc_phase),
      .done_o   (fc_done)
   );

   ballast_pin_drive u_pins (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase_i      (phase),
      .fc_phase_i   (fc_phase),
      .cs_mid_i     (cs_mid),
      .cs_lim_i     (cs_lim),
      .tch_charge_o (tch_charge),
      .tch_sink_o   (tch_sink),
      .tch_clamp_o  (tch_clamp),
      .eoi_clamp_o  (eoi_clamp),
      .freq_up_o    (freq_up_sink),
      .drv_en_o     (drv_en),
      .latched_o    (fault_latched)
   );

   // R1
   supply_off_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (!drv_en && !fault_latched));

   // R11
   shdn_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shdn_req && !fault_latched) |=> !drv_en);

   // R6
   run_entry_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RUN && $past(phase) == PH_IGN) |-> tch_clamp);

endmodule

// File: tb/ballast_seq_bench.sv
`timescale 1ns/1ps
module ballast_seq_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok, shdn_req, tch_hi, tch_lo, eoi_run;
   logic cs_test, cs_lim, cs_mid, cs_sat, eol_win, comp_low;
   logic tch_charge, tch_sink, tch_clamp, eoi_clamp, freq_up_sink, drv_en, fault_latched;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ballast_seq u_ballast_seq (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shdn_req(shdn_req),
      .tch_hi(tch_hi), .tch_lo(tch_lo), .eoi_run(eoi_run), .cs_test(cs_test),
      .cs_lim(cs_lim), .cs_mid(cs_mid), .cs_sat(cs_sat), .eol_win(eol_win),
      .comp_low(comp_low), .tch_charge(tch_charge), .tch_sink(tch_sink),
      .tch_clamp(tch_clamp), .eoi_clamp(eoi_clamp), .freq_up_sink(freq_up_sink),
      .drv_en(drv_en), .fault_latched(fault_latched)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic settle();
      #0.5;
   endtask

   task automatic clr_in();
      shdn_req = 0; tch_hi = 0; tch_lo = 0; eoi_run = 0; cs_test = 0;
      cs_lim = 0; cs_mid = 0; cs_sat = 0; eol_win = 0; comp_low = 0;
   endtask

   task automatic power_cycle();
      clr_in();
      supply_ok = 0;
      cyc();
   endtask

   task automatic go_ign();
      power_cycle();
      supply_ok = 1; cyc();
      tch_hi = 1; cyc();
      tch_hi = 0; tch_lo = 1; cyc();
      tch_lo = 0;
   endtask

   task automatic go_run();
      go_ign();
      eoi_run = 1; cyc();
   endtask

   task automatic t_reset();
      chk("R1", "reset drv_en", drv_en, 1'b0);
      chk("R1", "reset tch_clamp", tch_clamp, 1'b1);
      chk("R1", "reset eoi_clamp", eoi_clamp, 1'b1);
      chk("R1", "reset tch_charge", tch_charge, 1'b0);
      chk("R1", "reset latched", fault_latched, 1'b0);
   endtask

   task automatic t_preheat();
      power_cycle();
      supply_ok = 1; cyc();
      chk("R2", "preheat charge", tch_charge, 1'b1);
      chk("R3", "preheat eoi clamp", eoi_clamp, 1'b1);
      chk("R3", "preheat drv_en", drv_en, 1'b1);
      cyc();
      chk("R2", "still charging", tch_charge, 1'b1);
      tch_hi = 1; cyc(); tch_hi = 0;
      chk("R2", "float charge off", tch_charge, 1'b0);
      chk("R2", "float clamp off", tch_clamp, 1'b0);
      chk("R2", "float sink off", tch_sink, 1'b0);
      tch_lo = 1; cyc(); tch_lo = 0;
      chk("R2", "ignition tch clamp", tch_clamp, 1'b1);
      chk("R3", "ignition eoi released", eoi_clamp, 1'b0);
      cs_lim = 1; settle();
      chk("R7", "cs_lim no freq_up in ign", freq_up_sink, 1'b0);
      cs_lim = 0;
      eoi_run = 1; cyc();
      chk("R3", "run eoi released", eoi_clamp, 1'b0);
      cs_lim = 1; settle();
      chk("R7", "run freq_up on cs_lim", freq_up_sink, 1'b1);
      cs_lim = 0;
   endtask

   task automatic t_ign_cycle(input logic confirm);
      go_ign();
      cs_mid = 1; cs_lim = 1; settle();
      chk("R4", "ign freq_up", freq_up_sink, 1'b1);
      cyc(); cs_mid = 0; cs_lim = 0;
      chk("R4", "reduced charge", tch_charge, 1'b1);
      tch_hi = 1; cyc(); tch_hi = 0;
      chk("R4", "reduced active sink", tch_sink, 1'b1);
      chk("R4", "sink not clamp", tch_clamp, 1'b0);
      cs_lim = confirm; tch_lo = 1; cyc(); tch_lo = 0; cs_lim = 0;
      chk("R5", "ign verdict latched", fault_latched, confirm);
      chk("R5", "ign verdict drv_en", drv_en, !confirm);
      if (!confirm) begin
         chk("R4", "back to clamp", tch_clamp, 1'b1);
         eoi_run = 1; cyc();
         cs_lim = 1; settle();
         chk("R5", "dismissed then run", freq_up_sink, 1'b1);
         cs_lim = 0;
      end
   endtask

   task automatic t_run_abort();
      go_ign();
      cs_mid = 1; cyc(); cs_mid = 0;
      chk("R6", "cycle started", tch_charge, 1'b1);
      eoi_run = 1; cyc();
      chk("R6", "abort charge", tch_charge, 1'b0);
      chk("R6", "abort clamp", tch_clamp, 1'b1);
      cs_lim = 1; settle();
      chk("R6", "in run", freq_up_sink, 1'b1);
      cs_lim = 0;
   endtask

   task automatic t_ign_sat();
      go_ign();
      cs_sat = 1; cs_mid = 1; cs_lim = 1; cyc();
      chk("R9", "ign saturation latch", fault_latched, 1'b1);
      chk("R9", "ign saturation drv off", drv_en, 1'b0);
      clr_in(); cyc();
      chk("R12", "latch persists", fault_latched, 1'b1);
   endtask

   task automatic t_run_oc(input logic confirm);
      go_run();
      cs_lim = 1; cyc(); cs_lim = 0;
      chk("R7", "run oc charge", tch_charge, 1'b1);
      tch_hi = 1; cyc(); tch_hi = 0;
      chk("R7", "run oc sink", tch_sink, 1'b1);
      cs_test = confirm; tch_lo = 1; cyc(); tch_lo = 0; cs_test = 0;
      chk("R7", "run oc verdict", fault_latched, confirm);
      chk("R7", "run oc drv_en", drv_en, !confirm);
   endtask

   task automatic t_run_slow(input bit use_eol, input logic still);
      go_run();
      if (use_eol) eol_win = 1; else comp_low = 1;
      cyc(); eol_win = 0; comp_low = 0;
      chk("R8", "slow fault charge", tch_charge, 1'b1);
      tch_hi = 1; cyc(); tch_hi = 0;
      if (use_eol) eol_win = still; else comp_low = still;
      tch_lo = 1; cyc(); tch_lo = 0;
      chk("R8", use_eol ? "eol verdict" : "comp verdict", fault_latched, still);
      eol_win = 0; comp_low = 0;
   endtask

   task automatic t_run_sat();
      go_run();
      cs_mid = 1; cs_lim = 1; cyc(); cyc();
      cs_mid = 0; cs_lim = 0; cyc();
      chk("R10", "short spike no latch", fault_latched, 1'b0);
      chk("R10", "short spike drv on", drv_en, 1'b1);
      go_run();
      cs_mid = 1; cs_lim = 1; cyc(); cyc(); cyc();
      cs_mid = 0; cs_lim = 0;
      chk("R10", "held spike latched", fault_latched, 1'b1);
   endtask

   task automatic t_shutdown();
      go_run();
      shdn_req = 1; cyc();
      chk("R11", "shutdown drv off", drv_en, 1'b0);
      cyc();
      chk("R11", "held off", drv_en, 1'b0);
      shdn_req = 0; cyc();
      chk("R11", "restart preheat charge", tch_charge, 1'b1);
      chk("R11", "restart eoi clamp", eoi_clamp, 1'b1);
      go_ign();
      cs_sat = 1; cyc(); cs_sat = 0;
      shdn_req = 1; cyc(); shdn_req = 0; cyc();
      chk("R11", "shdn ignored latched", fault_latched, 1'b1);
      chk("R11", "no restart from latch", tch_charge, 1'b0);
      chk("R12", "latched clamps", tch_clamp & eoi_clamp, 1'b1);
      supply_ok = 0; cyc();
      chk("R1", "supply drop clears latch", fault_latched, 1'b0);
      chk("R1", "supply drop drv off", drv_en, 1'b0);
      supply_ok = 1; cyc();
      chk("R2", "fresh preheat after power cycle", tch_charge, 1'b1);
   endtask

   initial begin
      clr_in();
      supply_ok = 0;
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      t_reset();
      t_preheat();
      t_ign_cycle(1'b0);
      t_ign_cycle(1'b1);
      t_run_abort();
      t_ign_sat();
      t_run_oc(1'b0);
      t_run_oc(1'b1);
      t_run_slow(1'b1, 1'b1);
      t_run_slow(1'b1, 1'b0);
      t_run_slow(1'b0, 1'b1);
      t_run_slow(1'b0, 1'b0);
      t_run_sat();
      t_shutdown();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule